// File: doc/BRIEF.md
# Serial Loop Attach Controller

This block decides when a serial station on a bit-synchronous ring joins the ring, repeats traffic around it, places its own frame on it, and leaves it. It watches the received bit stream for runs of consecutive ones. A run of seven ones is the only event that moves the station onto the ring or off it. Whether such a run takes effect depends on two software control bits, a ring-enable bit and a poll-response enable bit.

Once attached, the station passes every received bit onward one bit time later. It keeps doing this until software asks to start a frame while the poll-response enable is set. While the station is sending, it serializes bytes from a simple byte/valid/last interface, least significant bit first. Whenever no byte is waiting, it fills the gap with a selectable idle pattern. When the final bit of the last byte has gone out, the station returns to repeating. A cleared ring-enable bit causes an orderly detach: the station stays on the ring until the next run of seven ones.

Everything advances on a bit-rate enable pulse. Framing, checksum generation and bit stuffing are handled elsewhere.

Top module: `loopAttach`

## Requirements
- R1: From the detached state, the station attaches on the bit that completes a run of seven consecutive received ones, but only if the ring-enable (`loopModeEn`) and the poll-response enable (`pollGoActive`) are both 1 at that bit. With either one at 0, the station stays detached.
- R2: `onLoop` reads 1 from the bit that attaches the station until the bit that detaches it, and 0 otherwise.
- R3: The bit that attaches the station sets both `brkAbort` and `hunt` to 1. Both flags stay at 1 until a one-cycle `flagClr` pulse clears them.
- R4: While attached and repeating, a bit with `frameStart`=1 and `pollGoActive`=1 starts a frame and raises `loopSending` after that bit. If `pollGoActive`=0, `frameStart` is ignored.
- R5: A started frame is not aborted when `pollGoActive` drops. Each accepted byte goes out on `txBit`, bit 0 first, over 8 bit times. `txReady` is high, during a bit-enable cycle, only when the station can take a new byte. `loopSending` falls on the bit after the last bit of the byte marked `txLast`, and on that bit the station resumes repeating.
- R6: After `loopModeEn` is cleared, the station stays attached until a new run of seven ones completes. On that bit `onLoop` goes to 0 and `brkAbort` and `hunt` are set to 1.
- R7: During a frame, a bit with no byte available sends idle fill. With `idleFlags`=1 the fill is the flag byte 0x7E sent bit 0 first (0,1,1,1,1,1,1,0, restarting at each frame). With `idleFlags`=0 the fill is all ones.
- R8: While attached and not sending, `txBit` after each bit equals the `rxBit` sampled on that bit, which is a delay of exactly one bit time.
- R9: While detached, `txBit` is 1.
- R10: A received zero resets the ones counter. The counter saturates at seven: a run that is already complete never re-triggers, however long it lasts.
- R11: After reset the station is detached, all status flags are 0 and `txBit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | One-cycle pulse per bit time |
| rxBit | input | 1 | Received serial bit, sampled when bitEn is high |
| loopModeEn | input | 1 | Ring-enable control bit |
| pollGoActive | input | 1 | Poll-response enable control bit |
| frameStart | input | 1 | Request to start the station's own frame |
| idleFlags | input | 1 | Idle fill select: 1 sends flag bytes, 0 sends ones |
| flagClr | input | 1 | Clear pulse for brkAbort and hunt |
| txByte | input | 8 | Frame byte to send |
| txValid | input | 1 | txByte is valid |
| txLast | input | 1 | txByte is the final byte of the frame |
| txReady | output | 1 | Byte taken this cycle if txValid is high |
| txBit | output | 1 | Transmitted serial bit |
| onLoop | output | 1 | Station is attached to the ring |
| loopSending | output | 1 | Station is sending its own frame |
| brkAbort | output | 1 | Latched seven-ones event flag |
| hunt | output | 1 | Latched seven-ones event flag (hunt) |

## Verification
Every result is registered once, at the clock edge where `bitEn` is high. The status outputs and `txBit` therefore show the effect of a bit one clock after that bit's enable. `txReady`, in contrast, is combinational and valid inside the enable cycle itself. The bench drives each bit for a single enable cycle and samples `txReady` 1 ns into that cycle. It reads every other output at the falling edge after the enable edge, so each expected value lines up with exactly one bit. Delayed effects are checked on the named bit: the end of sending on the ninth bit after the last byte is taken, and detaching on the seventh one after a zero.

// File: rtl/loopAttachPkg.sv
package loopAttachPkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_SEND = 2'd2,
    ST_EXIT = 2'd3
  } loopState_t;

  typedef struct packed {
    logic bitTick;
    logic repeatRx;
    logic sendActive;
    logic frameInit;
  } dpStrobe_t;
endpackage

// File: rtl/loopAttachCtrl.sv
module loopAttachCtrl
  import loopAttachPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      loopModeEn,
  input  logic      pollGoActive,
  input  logic      frameStart,
  input  logic      flagClr,
  input  logic      sevenHit,
  input  logic      frameDone,
  output dpStrobe_t strobe,
  output logic      onLoop,
  output logic      loopSending,
  output logic      brkAbort,
  output logic      hunt
);
  loopState_t state, stateNext;
  logic joinHit, leaveHit;

  assign joinHit  = bitEn && (state == ST_OFF) && sevenHit && loopModeEn && pollGoActive;
  assign leaveHit = bitEn && (state == ST_EXIT) && sevenHit;

  always_comb begin
    stateNext = state;
    if (bitEn) begin
      unique case (state)
        ST_OFF:  if (joinHit) stateNext = ST_ON;
        ST_ON: begin
          if (!loopModeEn) stateNext = ST_EXIT;
          else if (pollGoActive && frameStart) stateNext = ST_SEND;
        end
        ST_SEND: if (frameDone) stateNext = ST_ON;
        ST_EXIT: begin
          if (leaveHit) stateNext = ST_OFF;
          else if (loopModeEn) stateNext = ST_ON;
        end
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  // Latched event flags: a new seven-ones event wins over a clear pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkAbort <= 1'b0;
      hunt     <= 1'b0;
    end else if (joinHit || leaveHit) begin
      brkAbort <= 1'b1;
      hunt     <= 1'b1;
    end else if (flagClr) begin
      brkAbort <= 1'b0;
      hunt     <= 1'b0;
    end
  end

  always_comb begin
    strobe.bitTick    = bitEn;
    strobe.repeatRx   = (state == ST_ON) || (state == ST_EXIT);
    strobe.sendActive = (state == ST_SEND);
    strobe.frameInit  = bitEn && (state == ST_ON) && loopModeEn && pollGoActive && frameStart;
  end

  assign onLoop      = (state != ST_OFF);
  assign loopSending = (state == ST_SEND);
endmodule

// File: rtl/loopAttachDp.sv
module loopAttachDp
  import loopAttachPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int RUN_LEN = 7,
  parameter logic [BYTE_W-1:0] IDLE_FLAG = 8'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              rxBit,
  input  logic              idleFlags,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              txValid,
  input  logic              txLast,
  output logic              txReady,
  output logic              txBit,
  output logic              sevenHit,
  output logic              frameDone
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] RUN_PRE  = CNT_W'(RUN_LEN - 1);
  localparam logic [BIT_W-1:0] BIT_LOAD = BIT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  runCnt;
  logic [BYTE_W-1:0] shReg;
  logic [BIT_W-1:0]  bitsLeft;
  logic              lastLoaded;
  logic [IDX_W-1:0]  idlePhase;
  logic              idleBit;
  logic              slotFree;

  // Consecutive-ones counter, saturating at the run length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runCnt <= '0;
    else if (strobe.bitTick) begin
      if (!rxBit)               runCnt <= '0;
      else if (runCnt != RUN_MAX) runCnt <= runCnt + 1'b1;
    end
  end

  assign sevenHit  = strobe.bitTick && rxBit && (runCnt == RUN_PRE);
  assign slotFree  = strobe.sendActive && strobe.bitTick && (bitsLeft == '0);
  assign frameDone = slotFree && lastLoaded;
  assign txReady   = slotFree && !lastLoaded;
  assign idleBit   = idleFlags ? IDLE_FLAG[idlePhase] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg      <= '0;
      bitsLeft   <= '0;
      lastLoaded <= 1'b0;
      idlePhase  <= '0;
    end else if (strobe.frameInit) begin
      bitsLeft   <= '0;
      lastLoaded <= 1'b0;
      idlePhase  <= '0;
    end else if (strobe.bitTick && strobe.sendActive) begin
      if (frameDone) begin
        lastLoaded <= 1'b0;
      end else if (bitsLeft != '0) begin
        shReg    <= shReg >> 1;
        bitsLeft <= bitsLeft - 1'b1;
      end else if (txValid) begin
        shReg      <= txByte >> 1;
        bitsLeft   <= BIT_LOAD;
        lastLoaded <= txLast;
      end else begin
        idlePhase <= (idlePhase == IDX_LAST) ? '0 : idlePhase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txBit <= 1'b1;
    else if (strobe.bitTick) begin
      if (strobe.sendActive) begin
        if (frameDone)              txBit <= rxBit;
        else if (bitsLeft != '0)    txBit <= shReg[0];
        else if (txValid)           txBit <= txByte[0];
        else                        txBit <= idleBit;
      end else if (strobe.repeatRx) txBit <= rxBit;
      else                          txBit <= 1'b1;
    end
  end
endmodule

// File: rtl/loopAttach.sv
module loopAttach
  import loopAttachPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int RUN_LEN = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              rxBit,
  input  logic              loopModeEn,
  input  logic              pollGoActive,
  input  logic              frameStart,
  input  logic              idleFlags,
  input  logic              flagClr,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              txValid,
  input  logic              txLast,
  output logic              txReady,
  output logic              txBit,
  output logic              onLoop,
  output logic              loopSending,
  output logic              brkAbort,
  output logic              hunt
);
  dpStrobe_t strobe;
  logic sevenHit, frameDone;

  loopAttachCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn),
    .loopModeEn(loopModeEn), .pollGoActive(pollGoActive),
    .frameStart(frameStart), .flagClr(flagClr),
    .sevenHit(sevenHit), .frameDone(frameDone),
    .strobe(strobe), .onLoop(onLoop), .loopSending(loopSending),
    .brkAbort(brkAbort), .hunt(hunt)
  );

  loopAttachDp #(.BYTE_W(BYTE_W), .RUN_LEN(RUN_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxBit(rxBit),
    .idleFlags(idleFlags), .txByte(txByte), .txValid(txValid),
    .txLast(txLast), .txReady(txReady), .txBit(txBit),
    .sevenHit(sevenHit), .frameDone(frameDone)
  );
endmodule

// File: rtl/loopAttachChk.sv
module loopAttachChk (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic rxBit,
  input logic loopModeEn,
  input logic pollGoActive,
  input logic frameStart,
  input logic txReady,
  input logic txBit,
  input logic onLoop,
  input logic loopSending,
  input logic brkAbort,
  input logic hunt
);
  a_r1_join_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(onLoop) |-> $past(bitEn && rxBit && loopModeEn && pollGoActive));
  a_r3_join_flags: assert property (@(posedge clk) disable iff (!rstN)
    $rose(onLoop) |-> (brkAbort && hunt));
  a_r6_exit_flags: assert property (@(posedge clk) disable iff (!rstN)
    $fell(onLoop) |-> (brkAbort && hunt));
  a_r4_send_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopSending) |-> $past(bitEn && frameStart && pollGoActive));
  a_r2_send_on_loop: assert property (@(posedge clk) disable iff (!rstN)
    loopSending |-> onLoop);
  a_r5_ready_in_send: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (loopSending && bitEn));
  a_r8_repeat_delay: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && onLoop && !loopSending) |=> (txBit == $past(rxBit)));
  a_r9_passive_mark: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !onLoop) |=> txBit);
endmodule

bind loopAttach loopAttachChk i_chk (.*);

// File: tb/test_loopAttach.sv
module test_loopAttach;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, rxBit = 1'b1, loopModeEn = 1'b0, pollGoActive = 1'b0;
  logic frameStart = 1'b0, idleFlags = 1'b1, flagClr = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic txValid = 1'b0, txLast = 1'b0;
  logic txReady, txBit, onLoop, loopSending, brkAbort, hunt;
  logic took;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  loopAttach i_loopAttach (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    rxBit = b;
    bitEn = 1'b1;
    #1 took = txReady && txValid;
    @(negedge clk);
    bitEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic clearFlags();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  task automatic sendByte(input string req, input logic [7:0] b, input logic last);
    txByte = b; txValid = 1'b1; txLast = last;
    sendBit(1'b0);
    chk({req, " byte taken"}, took, 1'b1);
    chk({req, " bit0"}, txBit, b[0]);
    txValid = 1'b0; txLast = 1'b0;
    for (int i = 1; i < 8; i++) begin
      sendBit(1'b0);
      chk({req, " data bit"}, txBit, b[i]);
      chk({req, " no take mid-byte"}, took, 1'b0);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] idleExp;
    idleExp = 8'h7E;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 onLoop", onLoop, 1'b0);
    chk("R11 loopSending", loopSending, 1'b0);
    chk("R11 brkAbort", brkAbort, 1'b0);
    chk("R11 hunt", hunt, 1'b0);
    chk("R11 txBit", txBit, 1'b1);
    rstN = 1'b1;

    // R1: poll disabled, seven ones ignored; R9 stays mark
    loopModeEn = 1'b1; pollGoActive = 1'b0;
    sendBit(1'b0); ones(7);
    chk("R1 no join without poll", onLoop, 1'b0);
    chk("R9 passive mark", txBit, 1'b1);
    chk("R3 no flags without join", brkAbort, 1'b0);

    // R10: zero resets the counter
    pollGoActive = 1'b1;
    sendBit(1'b0); ones(5); sendBit(1'b0);
    chk("R9 passive after zero", txBit, 1'b1);
    ones(6);
    chk("R10 run broken by zero", onLoop, 1'b0);
    // R1/R2/R3: seventh one joins
    sendBit(1'b1);
    chk("R1 join on seventh one", onLoop, 1'b1);
    chk("R2 onLoop set", onLoop, 1'b1);
    chk("R3 brkAbort set", brkAbort, 1'b1);
    chk("R3 hunt set", hunt, 1'b1);
    sendBit(1'b0);
    chk("R3 brkAbort latched", brkAbort, 1'b1);
    clearFlags();
    chk("R3 brkAbort cleared", brkAbort, 1'b0);
    chk("R3 hunt cleared", hunt, 1'b0);

    // R8 repeat with one-bit delay
    pollGoActive = 1'b0;
    for (int i = 0; i < 12; i++) begin
      logic b;
      b = ((i * 5) % 3) == 1;
      sendBit(b);
      chk("R8 repeat", txBit, b);
    end

    // R4: frameStart ignored without poll
    frameStart = 1'b1;
    sendBit(1'b1);
    chk("R4 ignored without poll", loopSending, 1'b0);
    chk("R8 repeat on ignored start", txBit, 1'b1);
    // R4: start with poll
    pollGoActive = 1'b1;
    sendBit(1'b1);
    chk("R4 sending raised", loopSending, 1'b1);
    frameStart = 1'b0; pollGoActive = 1'b0;
    // R7 flag idle fill
    for (int i = 0; i < 3; i++) begin
      sendBit(1'b0);
      chk("R7 flag idle fill", txBit, idleExp[i]);
      chk("R5 no take without valid", took, 1'b0);
    end
    sendByte("R5 first", 8'hA5, 1'b0);
    chk("R5 not aborted by poll clear", loopSending, 1'b1);
    sendByte("R5 last", 8'h3C, 1'b1);
    chk("R5 sending until last bit done", loopSending, 1'b1);
    sendBit(1'b1);
    chk("R5 sending falls after frame", loopSending, 1'b0);
    chk("R5 resume repeat", txBit, 1'b1);
    chk("R2 still on loop", onLoop, 1'b1);

    // R7 mark idle fill on a second frame
    idleFlags = 1'b0; pollGoActive = 1'b1; frameStart = 1'b1;
    sendBit(1'b0);
    chk("R4 second frame", loopSending, 1'b1);
    frameStart = 1'b0; pollGoActive = 1'b0;
    for (int i = 0; i < 2; i++) begin
      sendBit(1'b0);
      chk("R7 mark idle fill", txBit, 1'b1);
    end
    sendByte("R5 single", 8'h81, 1'b1);
    sendBit(1'b0);
    chk("R5 single frame done", loopSending, 1'b0);
    chk("R8 repeat after frame", txBit, 1'b0);

    // R10 saturation, then R6 orderly exit
    ones(7);
    chk("R10 no rejoin event while on", brkAbort, 1'b0);
    loopModeEn = 1'b0;
    ones(9);
    chk("R10 saturated run does not detach", onLoop, 1'b1);
    sendBit(1'b0); ones(6);
    chk("R6 stays on before seventh", onLoop, 1'b1);
    chk("R6 no flags yet", hunt, 1'b0);
    sendBit(1'b1);
    chk("R6 detached", onLoop, 1'b0);
    chk("R6 brkAbort set on exit", brkAbort, 1'b1);
    chk("R6 hunt set on exit", hunt, 1'b1);
    sendBit(1'b0);
    chk("R9 mark after exit", txBit, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule